// File: doc/BRIEF.md
# Two-Way Data Cache Controller with Per-Access Write Policy

This block sits between a load/store unit and a memory port. It holds an 8 KB data cache organised as 128 sets of two ways, each line eight 32-bit words long. The core hands it one access at a time. Each access carries a two-bit cache attribute. The attribute picks how that one access is treated: bypassing the cache, write-back, write-through that allocates on a miss, or write-through that does not allocate.

On a load miss the controller asks memory for the whole line, starting from the word that was requested. It answers the core as soon as that word arrives, and the rest of the line keeps filling. A dirty victim is copied out to memory, one word at a time in ascending order, before the new line is fetched. Every data byte is stored with its own parity bit and every tag with one parity bit. A lock input keeps way A out of replacement, so code or data held there stays resident.

Top module: `dcache_ctrl`

## Requirements
- R1: After reset `req_ready` is 1, and `rsp_valid` and `mem_req_valid` are 0. Every line is invalid, so the first cached load of any address misses.
- R2: The set index is address bits 11..5, the word within a line is bits 4..2 and the tag is bits 31..12. Two lines with the same index and different tags are resident at once, one in each way.
- R3: A cached load miss issues exactly one read with `mem_req_line`=1 and `mem_req_addr` set to the requested word. The eight returned words are written to line word `crit XOR i` for beat i. Later loads of every word of that line hit, cause no memory traffic and return the memory values.
- R4: On a load miss, `rsp_valid` carries the critical word while `req_ready` is still 0, because the remaining words are still filling.
- R5: A store with attribute 1 (write-back) that hits merges only the bytes selected by `req_be` into the line. It causes no memory traffic and marks the line dirty. A write-back store miss first fills the line and then merges the store.
- R6: Replacing a dirty line sends eight single-word writes at word offsets 0 to 7 in ascending order, carrying the line's contents, all before the refill read. Replacing a clean line sends no writes.
- R7: A store with attribute 2 (write-through, allocate) updates the cached line and sends one write with the same address, byte enables and data. A miss fills the line first. The line's dirty bit is left as it was, so a line written only this way is evicted without a writeback, while a line already dirty stays dirty.
- R8: A store with attribute 3 (write-through, no allocate) that misses sends one write and no read, and allocates nothing. A hit updates the line and also writes memory.
- R9: Attribute 0 (uncached): a load issues a single-word read (`mem_req_line`=0) even when the line is cached. A store writes memory only, and a later cached load still returns the old cached value.
- R10: The refill victim is the first invalid way (A before B). If both ways are valid, the victim is taken from a per-set bit that flips on every refill. While `lock_a` is 1 the victim is always way B, and a line in way A keeps hitting.
- R11: Each data byte has a stored parity bit and each tag has one. A cached load reports `rsp_perr`=1 on a byte parity mismatch, and a tag whose parity mismatches counts as a miss. Data written through the controller reads back with `rsp_perr`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lock_a | input | 1 | Keep way A out of replacement |
| req_valid | input | 1 | Core access request |
| req_ready | output | 1 | Controller can accept an access |
| req_we | input | 1 | 1 = store, 0 = load |
| req_attr | input | 2 | 0 uncached, 1 write-back, 2 write-through allocate, 3 write-through no allocate |
| req_addr | input | 32 | Byte address (word aligned) |
| req_be | input | 4 | Store byte enables |
| req_wdata | input | 32 | Store data |
| rsp_valid | output | 1 | One-cycle completion pulse; carries load data |
| rsp_rdata | output | 32 | Load data |
| rsp_perr | output | 1 | Byte parity mismatch on a cached load |
| mem_req_valid | output | 1 | Memory request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_we | output | 1 | 1 = single-word write |
| mem_req_line | output | 1 | 1 = eight-word refill read |
| mem_req_addr | output | 32 | Word address (critical word for refills) |
| mem_req_be | output | 4 | Write byte enables |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Read data beat |
| mem_rsp_data | input | 32 | Read data |

## Verification
A wrong dirty bit shows up only when its line is evicted, possibly many accesses later: either eight unexpected writes or a missing writeback, the latter seen as stale data on a later reload. A misplaced refill beat shows as a wrong value on the first later hit to that word, which means every word of a refilled line has to be read back. A wrong valid bit or victim choice shows as an unexpected refill read, or a missing one, on the very next access to the set. The tests therefore count memory reads and writes around each access and revisit lines after eviction.

// File: rtl/dcache_pkg.sv
// Shared types and helpers for the data cache controller.
// Assumes 32-bit words; byte parity is even parity per byte.
package dcache_pkg;
    localparam int WORD_W = 32;
    localparam int BYTES  = WORD_W / 8;

    typedef enum logic [1:0] {
        ATTR_UNCACHED   = 2'd0,
        ATTR_WB         = 2'd1,
        ATTR_WT_ALLOC   = 2'd2,
        ATTR_WT_NOALLOC = 2'd3
    } cache_attr_t;

    typedef enum logic [2:0] {
        S_IDLE, S_LOOK, S_WB, S_FILL_REQ, S_FILL, S_MRD_REQ, S_MRD, S_MWR
    } dc_state_t;

    // Parity bit of each byte of a word
    function automatic logic [BYTES-1:0] byte_par(input logic [WORD_W-1:0] d);
        logic [BYTES-1:0] p;
        for (int b = 0; b < BYTES; b++) p[b] = ^d[8*b +: 8];
        return p;
    endfunction
endpackage

// File: rtl/dcache_tag_store.sv
// Tag, valid and dirty state for two ways.
// Combinational lookup at one index; one allocate or one dirty-set per cycle.
// Assumes allocate and dirty-set never address the same entry in one cycle.
module dcache_tag_store #(
    parameter int SETS  = 128,
    parameter int TAG_W = 20
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [$clog2(SETS)-1:0] idx,
    input  logic [TAG_W-1:0]        cmp_tag,
    input  logic                    alloc_we,
    input  logic                    alloc_way,
    input  logic                    dirty_we,
    input  logic                    dirty_way,
    output logic [1:0]              hit_vec,
    output logic [1:0]              val_vec,
    output logic [1:0]              dirty_vec,
    output logic [1:0][TAG_W-1:0]   way_tag
);
    for (genvar w = 0; w < 2; w++) begin : g_way
        logic [TAG_W-1:0] tag_a  [SETS];
        logic             tpar_a [SETS];
        logic [SETS-1:0]  vld;
        logic [SETS-1:0]  drt;

        // Valid and dirty flags per line
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld <= '0;
                drt <= '0;
            end else if (alloc_we && alloc_way == 1'(w)) begin
                vld[idx] <= 1'b1;
                drt[idx] <= 1'b0;
            end else if (dirty_we && dirty_way == 1'(w)) begin
                drt[idx] <= 1'b1;
            end
        end

        // Tag and tag parity written on allocation
        always_ff @(posedge clk) begin
            if (alloc_we && alloc_way == 1'(w)) begin
                tag_a[idx]  <= cmp_tag;
                tpar_a[idx] <= ^cmp_tag;
            end
        end

        assign val_vec[w]   = vld[idx];
        assign dirty_vec[w] = drt[idx];
        assign way_tag[w]   = tag_a[idx];
        assign hit_vec[w]   = vld[idx] && (tag_a[idx] == cmp_tag)
                              && (tpar_a[idx] == ^tag_a[idx]);
    end
endmodule

// File: rtl/dcache_data_store.sv
// Data words with byte parity for two ways, one word per entry.
// Combinational read of both ways; byte-enabled write merges with old content.
module dcache_data_store
    import dcache_pkg::*;
#(
    parameter int SETS       = 128,
    parameter int LINE_WORDS = 8
) (
    input  logic                                      clk,
    input  logic [$clog2(SETS)+$clog2(LINE_WORDS)-1:0] raddr,
    input  logic                                      we,
    input  logic                                      way,
    input  logic [$clog2(SETS)+$clog2(LINE_WORDS)-1:0] waddr,
    input  logic [BYTES-1:0]                          be,
    input  logic [WORD_W-1:0]                         wdata,
    output logic [1:0][WORD_W-1:0]                    rd_data,
    output logic [1:0]                                rd_perr
);
    localparam int DEPTH = SETS * LINE_WORDS;
    localparam int ENT_W = WORD_W + BYTES;

    for (genvar w = 0; w < 2; w++) begin : g_way
        logic [ENT_W-1:0]  arr [DEPTH];
        logic [WORD_W-1:0] old_w;
        logic [WORD_W-1:0] merged;

        // Byte merge of the store data into the stored word
        always_comb begin
            old_w = arr[waddr][WORD_W-1:0];
            for (int b = 0; b < BYTES; b++)
                merged[8*b +: 8] = be[b] ? wdata[8*b +: 8] : old_w[8*b +: 8];
        end

        // Array write with recomputed parity
        always_ff @(posedge clk) begin
            if (we && way == 1'(w)) arr[waddr] <= {byte_par(merged), merged};
        end

        assign rd_data[w] = arr[raddr][WORD_W-1:0];
        assign rd_perr[w] = |(arr[raddr][ENT_W-1:WORD_W] ^ byte_par(arr[raddr][WORD_W-1:0]));
    end
endmodule

// File: rtl/dcache_victim.sv
// Refill way choice: invalid way first, else a per-set alternating bit;
// the lock forces way B. The bit flips on each refill of its set.
module dcache_victim #(
    parameter int SETS = 128
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [$clog2(SETS)-1:0] idx,
    input  logic [1:0]              val_vec,
    input  logic                    lock_a,
    input  logic                    upd,
    output logic                    vic_way
);
    logic [SETS-1:0] rr;

    // Alternating replacement bit per set
    always_ff @(posedge clk) begin
        if (!rst_n)   rr <= '0;
        else if (upd) rr[idx] <= ~rr[idx];
    end

    // Victim selection
    always_comb begin
        if (lock_a)          vic_way = 1'b1;
        else if (!val_vec[0]) vic_way = 1'b0;
        else if (!val_vec[1]) vic_way = 1'b1;
        else                  vic_way = rr[idx];
    end
endmodule

// File: rtl/dcache_ctrl.sv
// Two-way data cache controller with a per-access write policy.
// One access in flight; the request is captured, then looked up one cycle later.
// Memory port: single-word reads/writes, eight-beat refills returning word
// crit^i on beat i. Assumes lock_a is stable while a miss is being served.
module dcache_ctrl
    import dcache_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int SETS       = 128,
    parameter int LINE_WORDS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lock_a,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_we,
    input  logic [1:0]        req_attr,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [3:0]        req_be,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata,
    output logic              rsp_perr,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_we,
    output logic              mem_req_line,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [3:0]        mem_req_be,
    output logic [31:0]       mem_req_wdata,
    input  logic              mem_rsp_valid,
    input  logic [31:0]       mem_rsp_data
);
    localparam int IDX_W  = $clog2(SETS);
    localparam int WSEL_W = $clog2(LINE_WORDS);
    localparam int OFF_W  = WSEL_W + 2;
    localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
    localparam logic [WSEL_W-1:0] LAST_BEAT = WSEL_W'(LINE_WORDS - 1);

    dc_state_t         state;
    cache_attr_t       q_attr;
    logic              q_we;
    logic [ADDR_W-1:0] q_addr;
    logic [3:0]        q_be;
    logic [31:0]       q_wdata;
    logic              q_way;
    logic [WSEL_W-1:0] beat;

    logic [IDX_W-1:0]  q_idx;
    logic [WSEL_W-1:0] q_word;
    logic [TAG_W-1:0]  q_tag;
    logic [1:0]        hit_vec, val_vec, dirty_vec, rd_perr;
    logic [1:0][TAG_W-1:0]  way_tag;
    logic [1:0][31:0]  rd_data;
    logic              vic_way, hit, hw, cached;
    logic              alloc_we, dirty_we, store_hit, fill_we, dat_we, dat_way;
    logic [WSEL_W-1:0] rd_word, wr_word;
    logic [3:0]        dat_be;
    logic [31:0]       dat_wdata;

    assign q_idx  = q_addr[OFF_W +: IDX_W];
    assign q_word = q_addr[2 +: WSEL_W];
    assign q_tag  = q_addr[ADDR_W-1 -: TAG_W];
    assign cached = (q_attr != ATTR_UNCACHED);
    assign hit    = |hit_vec;
    assign hw     = hit_vec[1];
    assign req_ready = (state == S_IDLE);

    // Array control decoded from the state
    assign alloc_we  = (state == S_FILL_REQ) && mem_req_ready;
    assign store_hit = (state == S_LOOK) && cached && hit && q_we;
    assign dirty_we  = store_hit && (q_attr == ATTR_WB);
    assign fill_we   = (state == S_FILL) && mem_rsp_valid;
    assign dat_we    = store_hit || fill_we;
    assign dat_way   = fill_we ? q_way : hw;
    assign wr_word   = fill_we ? (q_word ^ beat) : q_word;
    assign dat_be    = fill_we ? 4'hF : q_be;
    assign dat_wdata = fill_we ? mem_rsp_data : q_wdata;
    assign rd_word   = (state == S_WB) ? beat : q_word;

    dcache_tag_store #(.SETS(SETS), .TAG_W(TAG_W)) u_tags (
        .clk(clk), .rst_n(rst_n), .idx(q_idx), .cmp_tag(q_tag),
        .alloc_we(alloc_we), .alloc_way(q_way),
        .dirty_we(dirty_we), .dirty_way(hw),
        .hit_vec(hit_vec), .val_vec(val_vec), .dirty_vec(dirty_vec), .way_tag(way_tag)
    );

    dcache_data_store #(.SETS(SETS), .LINE_WORDS(LINE_WORDS)) u_data (
        .clk(clk), .raddr({q_idx, rd_word}), .we(dat_we), .way(dat_way),
        .waddr({q_idx, wr_word}), .be(dat_be), .wdata(dat_wdata),
        .rd_data(rd_data), .rd_perr(rd_perr)
    );

    dcache_victim #(.SETS(SETS)) u_vic (
        .clk(clk), .rst_n(rst_n), .idx(q_idx), .val_vec(val_vec),
        .lock_a(lock_a), .upd(alloc_we), .vic_way(vic_way)
    );

    // Memory request drive per state
    always_comb begin
        mem_req_valid = 1'b0;
        mem_req_we    = 1'b0;
        mem_req_line  = 1'b0;
        mem_req_addr  = {q_addr[ADDR_W-1:2], 2'b00};
        mem_req_be    = 4'hF;
        mem_req_wdata = q_wdata;
        unique case (state)
            S_WB: begin
                mem_req_valid = 1'b1;
                mem_req_we    = 1'b1;
                mem_req_addr  = {way_tag[q_way], q_idx, beat, 2'b00};
                mem_req_wdata = rd_data[q_way];
            end
            S_FILL_REQ: begin
                mem_req_valid = 1'b1;
                mem_req_line  = 1'b1;
            end
            S_MRD_REQ: mem_req_valid = 1'b1;
            S_MWR: begin
                mem_req_valid = 1'b1;
                mem_req_we    = 1'b1;
                mem_req_be    = q_be;
            end
            default: ;
        endcase
    end

    // Capture of the accepted request
    always_ff @(posedge clk) begin
        if (state == S_IDLE && req_valid) begin
            q_we    <= req_we;
            q_attr  <= cache_attr_t'(req_attr);
            q_addr  <= req_addr;
            q_be    <= req_be;
            q_wdata <= req_wdata;
        end
    end

    // Policy state machine and response generation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            beat      <= '0;
            q_way     <= 1'b0;
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
            rsp_perr  <= 1'b0;
        end else begin
            rsp_valid <= 1'b0;
            unique case (state)
                S_IDLE: if (req_valid) state <= S_LOOK;
                S_LOOK: begin
                    if (!cached) begin
                        state <= q_we ? S_MWR : S_MRD_REQ;
                    end else if (hit && !q_we) begin
                        rsp_valid <= 1'b1;
                        rsp_rdata <= rd_data[hw];
                        rsp_perr  <= rd_perr[hw];
                        state     <= S_IDLE;
                    end else if (hit) begin
                        if (q_attr == ATTR_WB) begin
                            rsp_valid <= 1'b1;
                            rsp_rdata <= '0;
                            rsp_perr  <= 1'b0;
                            state     <= S_IDLE;
                        end else begin
                            state <= S_MWR;
                        end
                    end else if (q_we && q_attr == ATTR_WT_NOALLOC) begin
                        state <= S_MWR;
                    end else begin
                        q_way <= vic_way;
                        beat  <= '0;
                        state <= (val_vec[vic_way] && dirty_vec[vic_way]) ? S_WB : S_FILL_REQ;
                    end
                end
                S_WB: if (mem_req_ready) begin
                    if (beat == LAST_BEAT) begin
                        beat  <= '0;
                        state <= S_FILL_REQ;
                    end else begin
                        beat <= beat + 1'b1;
                    end
                end
                S_FILL_REQ: if (mem_req_ready) begin
                    beat  <= '0;
                    state <= S_FILL;
                end
                S_FILL: if (mem_rsp_valid) begin
                    if (beat == '0 && !q_we) begin
                        rsp_valid <= 1'b1;
                        rsp_rdata <= mem_rsp_data;
                        rsp_perr  <= 1'b0;
                    end
                    if (beat == LAST_BEAT) begin
                        beat  <= '0;
                        state <= q_we ? S_LOOK : S_IDLE;
                    end else begin
                        beat <= beat + 1'b1;
                    end
                end
                S_MRD_REQ: if (mem_req_ready) state <= S_MRD;
                S_MRD: if (mem_rsp_valid) begin
                    rsp_valid <= 1'b1;
                    rsp_rdata <= mem_rsp_data;
                    rsp_perr  <= 1'b0;
                    state     <= S_IDLE;
                end
                S_MWR: if (mem_req_ready) begin
                    rsp_valid <= 1'b1;
                    rsp_rdata <= '0;
                    rsp_perr  <= 1'b0;
                    state     <= S_IDLE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/dcache_ctrl_chk.sv
// Property checker for dcache_ctrl, attached with bind.
module dcache_ctrl_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic              mem_req_we,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic              dat_we,
    input logic              alloc_we,
    input logic              q_we,
    input logic [1:0]        q_attr
);
    // R9
    uncached_no_array_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dat_we |-> q_attr != 2'd0);

    // R8
    noalloc_store_no_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_we |-> !(q_we && q_attr == 2'd3));

    // R3
    mem_req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we));

    // R4
    single_rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R1
    busy_while_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !req_ready);
endmodule

bind dcache_ctrl dcache_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
    .dat_we(dat_we), .alloc_we(alloc_we), .q_we(q_we), .q_attr(q_attr)
);

// File: tb/sim_dcache_ctrl.sv
// Directed bench for dcache_ctrl with a behavioural memory model.
module sim_dcache_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n, lock_a, req_valid, req_ready, req_we;
    logic [1:0]  req_attr;
    logic [31:0] req_addr, req_wdata, rsp_rdata, mem_req_addr, mem_req_wdata, mem_rsp_data;
    logic [3:0]  req_be, mem_req_be;
    logic        rsp_valid, rsp_perr, mem_req_valid, mem_req_ready, mem_req_we, mem_req_line;
    logic        mem_rsp_valid;

    int tests = 0, fails = 0;
    bit done = 0;

    logic [31:0] bmem [16384];
    int          rd_cnt = 0, wr_cnt = 0, wr_at_rd = 0;
    logic [31:0] last_rd_addr;
    logic        last_rd_line;
    logic [31:0] wr_log [16];
    logic [31:0] got_data;
    logic        got_ready, got_perr;

    always #(CLK_PERIOD/2) clk = ~clk;

    dcache_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .lock_a(lock_a),
        .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
        .req_attr(req_attr), .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_perr(rsp_perr),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_we(mem_req_we),
        .mem_req_line(mem_req_line), .mem_req_addr(mem_req_addr), .mem_req_be(mem_req_be),
        .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
    );

    function automatic logic [31:0] init_val(input int i);
        return (32'(i) * 32'h9E37_79B1) ^ 32'h1357_9BDF;
    endfunction

    // Memory model: always ready, refill beats in crit^k order
    initial begin
        int fill_base, fill_k, beats_left;
        logic [2:0] fill_crit;
        beats_left = 0; fill_base = 0; fill_k = 0; fill_crit = '0;
        for (int i = 0; i < 16384; i++) bmem[i] = init_val(i);
        mem_req_ready = 1'b1;
        mem_rsp_valid = 1'b0;
        mem_rsp_data  = '0;
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            if (beats_left > 0) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = bmem[fill_base + int'(fill_crit ^ 3'(fill_k))];
                fill_k++;
                beats_left--;
            end
            if (rst_n && mem_req_valid) begin
                if (mem_req_we) begin
                    for (int b = 0; b < 4; b++)
                        if (mem_req_be[b]) bmem[mem_req_addr[15:2]][8*b +: 8] = mem_req_wdata[8*b +: 8];
                    wr_log[wr_cnt % 16] = mem_req_addr;
                    wr_cnt++;
                end else begin
                    rd_cnt++;
                    last_rd_addr = mem_req_addr;
                    last_rd_line = mem_req_line;
                    wr_at_rd     = wr_cnt;
                    fill_k       = 0;
                    if (mem_req_line) begin
                        fill_base  = int'(mem_req_addr[15:5]) * 8;
                        fill_crit  = mem_req_addr[4:2];
                        beats_left = 8;
                    end else begin
                        fill_base  = int'(mem_req_addr[15:2]);
                        fill_crit  = '0;
                        beats_left = 1;
                    end
                end
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wait_idle();
        while (!req_ready) @(negedge clk);
    endtask

    // One core access; captures response data and ready at the response
    task automatic acc(input logic we, input logic [1:0] attr, input logic [31:0] addr,
                       input logic [3:0] be, input logic [31:0] wd);
        int n;
        @(negedge clk);
        wait_idle();
        req_valid = 1'b1; req_we = we; req_attr = attr;
        req_addr = addr; req_be = be; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        n = 0;
        while (!rsp_valid && n < 100) begin
            @(negedge clk);
            n++;
        end
        got_data  = rsp_rdata;
        got_ready = req_ready;
        got_perr  = rsp_perr;
        if (n >= 100) chk("R3 response timeout", 32'(n), 32'd0);
        // R11: data written through the controller reads back without parity error
        if (!we && attr != 2'd0) chk("R11 rsp_perr", 32'(got_perr), 32'd0);
        wait_idle();
    endtask

    task automatic t_reset();
        rst_n = 1'b0; lock_a = 1'b0; req_valid = 1'b0; req_we = 1'b0;
        req_attr = '0; req_addr = '0; req_be = '0; req_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 req_ready", 32'(req_ready), 32'd1);
        chk("R1 rsp_valid", 32'(rsp_valid), 32'd0);
        chk("R1 mem_req_valid", 32'(mem_req_valid), 32'd0);
    endtask

    // R3 and R4: load miss, critical word first, whole line placed
    task automatic t_load_miss();
        int r0;
        r0 = rd_cnt;
        acc(1'b0, 2'd1, 32'h14, 4'hF, '0);
        chk("R1 first load misses", 32'(rd_cnt - r0), 32'd1);
        chk("R3 refill address", last_rd_addr, 32'h14);
        chk("R3 refill line flag", 32'(last_rd_line), 32'd1);
        chk("R4 critical word data", got_data, init_val(5));
        chk("R4 ready low at restart", 32'(got_ready), 32'd0);
        r0 = rd_cnt;
        for (int w = 0; w < 8; w++) begin
            acc(1'b0, 2'd1, 32'(4*w), 4'hF, '0);
            chk("R3 word placement", got_data, init_val(w));
        end
        chk("R3 line hits no reads", 32'(rd_cnt - r0), 32'd0);
    endtask

    // R5 R6 R7 R2 R10: dirty line, write-through on dirty line, eviction
    task automatic t_writeback();
        int r0, w0;
        logic [31:0] merged;
        merged = {init_val(2)[31:16], 16'hBEEF};
        w0 = wr_cnt; r0 = rd_cnt;
        acc(1'b1, 2'd1, 32'h08, 4'b0011, 32'hDEAD_BEEF);
        chk("R5 wb store hit no write", 32'(wr_cnt - w0), 32'd0);
        acc(1'b0, 2'd1, 32'h08, 4'hF, '0);
        chk("R5 byte merge", got_data, merged);
        w0 = wr_cnt;
        acc(1'b1, 2'd2, 32'h0C, 4'hF, 32'h1234_5678);
        chk("R7 wt hit writes once", 32'(wr_cnt - w0), 32'd1);
        chk("R7 wt write address", wr_log[(wr_cnt - 1) % 16], 32'h0C);
        acc(1'b0, 2'd1, 32'h0C, 4'hF, '0);
        chk("R7 wt hit updates cache", got_data, 32'h1234_5678);
        chk("R5 hits no reads", 32'(rd_cnt - r0), 32'd0);
        w0 = wr_cnt;
        acc(1'b0, 2'd1, 32'h1000, 4'hF, '0);
        chk("R2 second tag no writeback", 32'(wr_cnt - w0), 32'd0);
        acc(1'b0, 2'd1, 32'h04, 4'hF, '0);
        chk("R2 both tags resident", got_data, init_val(1));
        w0 = wr_cnt;
        acc(1'b0, 2'd1, 32'h2000, 4'hF, '0);
        chk("R6 dirty victim eight writes", 32'(wr_cnt - w0), 32'd8);
        chk("R6 writes before refill", 32'(wr_at_rd - w0), 32'd8);
        for (int i = 0; i < 8; i++)
            chk("R6 ascending word order", wr_log[(w0 + i) % 16], 32'(4*i));
        chk("R6 written line data", bmem[2], merged);
        chk("R7 dirty kept by wt store", bmem[3], 32'h1234_5678);
        w0 = wr_cnt; r0 = rd_cnt;
        acc(1'b0, 2'd1, 32'h08, 4'hF, '0);
        chk("R10 alternating victim clean", 32'(wr_cnt - w0), 32'd0);
        chk("R6 reload after eviction", got_data, merged);
        chk("R10 reload read", 32'(rd_cnt - r0), 32'd1);
    endtask

    // R7: write-through allocate miss, line stays clean
    task automatic t_wt_clean();
        int r0, w0;
        r0 = rd_cnt; w0 = wr_cnt;
        acc(1'b1, 2'd2, 32'h4020, 4'hF, 32'hA1A2_A3A4);
        chk("R7 miss refills", 32'(rd_cnt - r0), 32'd1);
        chk("R7 miss refill address", last_rd_addr, 32'h4020);
        chk("R7 miss writes once", 32'(wr_cnt - w0), 32'd1);
        acc(1'b0, 2'd1, 32'h4020, 4'hF, '0);
        chk("R7 allocated data", got_data, 32'hA1A2_A3A4);
        w0 = wr_cnt;
        acc(1'b0, 2'd1, 32'h5020, 4'hF, '0);
        acc(1'b0, 2'd1, 32'h6020, 4'hF, '0);
        chk("R7 clean victim no writeback", 32'(wr_cnt - w0), 32'd0);
    endtask

    // R8: write-through without allocate
    task automatic t_noalloc();
        int r0, w0;
        r0 = rd_cnt; w0 = wr_cnt;
        acc(1'b1, 2'd3, 32'h60, 4'hF, 32'hCAFE_0001);
        chk("R8 miss one write", 32'(wr_cnt - w0), 32'd1);
        chk("R8 miss no read", 32'(rd_cnt - r0), 32'd0);
        acc(1'b0, 2'd1, 32'h60, 4'hF, '0);
        chk("R8 no allocation", 32'(rd_cnt - r0), 32'd1);
        chk("R8 memory got data", got_data, 32'hCAFE_0001);
        r0 = rd_cnt; w0 = wr_cnt;
        acc(1'b1, 2'd3, 32'h64, 4'hF, 32'h0BAD_F00D);
        chk("R8 hit writes memory", 32'(wr_cnt - w0), 32'd1);
        acc(1'b0, 2'd1, 32'h64, 4'hF, '0);
        chk("R8 hit updates cache", got_data, 32'h0BAD_F00D);
        chk("R8 hit no read", 32'(rd_cnt - r0), 32'd0);
    endtask

    // R9: uncached accesses
    task automatic t_uncached();
        int r0, w0;
        r0 = rd_cnt;
        acc(1'b0, 2'd0, 32'h64, 4'hF, '0);
        chk("R9 uncached load reads", 32'(rd_cnt - r0), 32'd1);
        chk("R9 single word read", 32'(last_rd_line), 32'd0);
        chk("R9 uncached load data", got_data, 32'h0BAD_F00D);
        w0 = wr_cnt;
        acc(1'b1, 2'd0, 32'h64, 4'hF, 32'h7777_7777);
        chk("R9 uncached store writes", 32'(wr_cnt - w0), 32'd1);
        r0 = rd_cnt;
        acc(1'b0, 2'd1, 32'h64, 4'hF, '0);
        chk("R9 cache left unchanged", got_data, 32'h0BAD_F00D);
        chk("R9 cached hit no read", 32'(rd_cnt - r0), 32'd0);
        acc(1'b0, 2'd0, 32'h64, 4'hF, '0);
        chk("R9 memory holds store", got_data, 32'h7777_7777);
    endtask

    // R10: way A lock
    task automatic t_lock();
        int r0;
        acc(1'b0, 2'd1, 32'h00A0, 4'hF, '0);
        acc(1'b0, 2'd1, 32'h10A0, 4'hF, '0);
        lock_a = 1'b1;
        acc(1'b0, 2'd1, 32'h20A0, 4'hF, '0);
        r0 = rd_cnt;
        acc(1'b0, 2'd1, 32'h00A0, 4'hF, '0);
        chk("R10 locked way hits", 32'(rd_cnt - r0), 32'd0);
        chk("R10 locked data", got_data, init_val(40));
        acc(1'b0, 2'd1, 32'h30A0, 4'hF, '0);
        r0 = rd_cnt;
        acc(1'b0, 2'd1, 32'h00A0, 4'hF, '0);
        chk("R10 locked way survives", 32'(rd_cnt - r0), 32'd0);
        acc(1'b0, 2'd1, 32'h10A0, 4'hF, '0);
        chk("R10 way B replaced", 32'(rd_cnt - r0), 32'd1);
        lock_a = 1'b0;
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog R3 act=hung exp=done");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_load_miss();
        t_writeback();
        t_wt_clean();
        t_noalloc();
        t_uncached();
        t_lock();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule